// File: doc/BRIEF.md
# Watchdog Timer with Programmable Prescaler

This block guards a small microcontroller core against runaway software. It counts tick strobes from one of two sources: a free-running oscillator tick, or the instruction-clock tick (the system clock divided by four, produced outside this block). Every tick first passes through a fixed divide-by-256 stage. The carry from that stage then feeds a prescaler whose ratio, from 1:1 up to 1:128, comes from the low three bits of an 8-bit control register. When the prescaler wraps, the watchdog has timed out.

What a time-out does depends on the core's state. If the core is running, the block pulses a chip-reset request and sets a sticky time-out flag. If the core is halted, it pulses only a warm-reset request, which the surrounding logic uses to zero the program counter and the stack pointer. Three events clear the count: a software clear command, entry into halt, or the external reset. A global enable freezes the whole watchdog when it is low. While the instruction clock is the source, halting stops the count.

Top module: `wdog_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets. After that edge `reg_rdata` reads 8'hFF, and `timeout_flag`, `chip_rst_req` and `warm_rst_req` are all 0.
- R2: A time-out occurs after exactly 256 × 2^k ticks of the selected source, counted from the last clear. Here k is `reg_rdata[2:0]`: code 0 gives 1:1, code 1 gives 1:2, and so on up to code 7, which gives 1:128.
- R3: When `src_sel`=0 the block counts `osc_tick`, and when `src_sel`=1 it counts `instr_tick`. The source that is not selected has no effect.
- R4: A time-out while `halted`=0 makes `chip_rst_req` high for exactly one cycle, in the cycle after the final tick. From that same cycle `timeout_flag` reads 1, and `warm_rst_req` stays 0.
- R5: A time-out while `halted`=1 makes `warm_rst_req` high for exactly one cycle. `chip_rst_req` stays 0 and `timeout_flag` does not change.
- R6: When `clr_wdt` is high and `wd_enable` is 1, the fixed stage and the prescaler restart from zero and `timeout_flag` clears. If a clear arrives in the same cycle as the final tick, the clear wins and no request is issued.
- R7: When `halted` rises, the count restarts from zero. While `halted`=1 and `src_sel`=1, ticks are not counted and no time-out occurs.
- R8: While `wd_enable`=0 the count holds its value. `clr_wdt` and halt entry have no effect, and no request is issued. Once the enable returns, counting resumes from the held value.
- R9: Bits 7:3 of the control register are read/write user flags that do not affect timing. A write with `reg_we`=1 stores all 8 bits of `reg_wdata`.
- R10: After a time-out the count restarts from zero, so the next time-out takes another full period.
- R11: The external reset in the middle of a count restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low external reset, sampled synchronously |
| wd_enable | input | 1 | Global watchdog enable (configuration) |
| src_sel | input | 1 | Count source: 0 = oscillator tick, 1 = instruction-clock tick |
| osc_tick | input | 1 | One-cycle strobe from the dedicated oscillator |
| instr_tick | input | 1 | One-cycle strobe from the instruction clock |
| halted | input | 1 | Core is in halt |
| clr_wdt | input | 1 | Software clear command |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| timeout_flag | output | 1 | Sticky time-out status |
| chip_rst_req | output | 1 | One-cycle chip-reset request |
| warm_rst_req | output | 1 | One-cycle warm-reset request |

## Verification
The count itself is never visible at the ports. A corrupted fixed-stage or prescaler value therefore shows up only as a request that arrives at the wrong tick: too early, too late, or never. At the 1:1 ratio this surfaces within at most 256 source ticks; at 1:128 it can take up to 32768 ticks. For this reason the bench counts ticks exactly, from each clear to the request. A wrong halt-state capture shows up at once, as the wrong request kind or a wrong `timeout_flag`, in the cycle after the final tick.

// File: rtl/wdog_pkg.sv
// Shared sizes and encodings for the watchdog.
// Assumes a single clock domain; every counting source is a one-cycle strobe.
package wdog_pkg;
    localparam int DIV_W  = 8;   // fixed divider stages (divide by 2^DIV_W)
    localparam int SEL_W  = 3;   // prescaler select field width
    localparam int REG_W  = 8;   // control register width

    typedef enum logic {
        SRC_OSC   = 1'b0,
        SRC_INSTR = 1'b1
    } wdog_src_e;
endpackage

// File: rtl/wdog_tick_sel.sv
// Picks the counting source and gates it with the enable and the halt state.
// Assumes both tick inputs are synchronous one-cycle strobes.
module wdog_tick_sel
    import wdog_pkg::*;
(
    input  logic osc_tick,
    input  logic instr_tick,
    input  logic src_sel,
    input  logic enable,
    input  logic halted,
    output logic tick_out
);
    logic raw_tick;
    logic frozen;

    // choose the selected source
    always_comb begin
        raw_tick = (wdog_src_e'(src_sel) == SRC_INSTR) ? instr_tick : osc_tick;
    end

    // the instruction clock stops while halted; disabled means no counting
    always_comb begin
        frozen   = halted && (wdog_src_e'(src_sel) == SRC_INSTR);
        tick_out = raw_tick && enable && !frozen;
    end
endmodule

// File: rtl/wdog_counter_chain.sv
// Fixed 2^DIV_W divider followed by a prescaler of ratio 2^sel.
// ovf is combinational and fires in the cycle the final tick is accepted.
// A clear has priority over a tick; after an overflow both stages restart at zero.
module wdog_counter_chain #(
    parameter int DIV_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             ovf
);
    localparam int PS_W = (2 ** SEL_W) - 1;

    logic [DIV_W-1:0] div_cnt;
    logic [PS_W-1:0]  ps_cnt;
    logic [PS_W-1:0]  ps_mask;
    logic             div_carry;
    logic             ps_wrap;

    // prescaler bits that take part at the selected ratio
    always_comb begin
        for (int i = 0; i < PS_W; i++) begin
            ps_mask[i] = (i < int'(sel));
        end
    end

    // carry out of each stage for the current tick
    always_comb begin
        div_carry = tick && (&div_cnt);
        ps_wrap   = ((ps_cnt & ps_mask) == ps_mask);
        ovf       = div_carry && ps_wrap && !clear;
    end

    // advance the divider and prescaler, clearing on request or overflow
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            div_cnt <= '0;
            ps_cnt  <= '0;
        end else if (tick) begin
            div_cnt <= div_cnt + DIV_W'(1);
            if (div_carry) begin
                ps_cnt <= ps_wrap ? '0 : ps_cnt + PS_W'(1);
            end
        end
    end

    p_wrap_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (div_cnt == '0 && ps_cnt == '0))
        else $error("count did not restart after overflow");

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> ($stable(div_cnt) && $stable(ps_cnt)))
        else $error("count moved without a tick");

    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (div_cnt == '0 && ps_cnt == '0))
        else $error("clear did not zero the count");
endmodule

// File: rtl/wdog_ctrl_reg.sv
// Control/status register: low SEL_W bits pick the prescaler ratio, the rest are user flags.
// Reset value is all ones (largest ratio).
module wdog_ctrl_reg #(
    parameter int REG_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic [SEL_W-1:0] sel
);
    logic [REG_W-1:0] ctrl_q;

    // store a full write; reset to all ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '1;
        end else if (we) begin
            ctrl_q <= wdata;
        end
    end

    assign rdata = ctrl_q;
    assign sel   = ctrl_q[SEL_W-1:0];

    p_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdata == $past(wdata)))
        else $error("register write lost");
endmodule

// File: rtl/wdog_top.sv
// Watchdog top: source selection, divider chain, control register,
// and the time-out reaction (chip reset vs warm reset by halt state).
// Assumes one clock domain; rst_n is the external active-low reset, sampled synchronously.
module wdog_top
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wd_enable,
    input  logic             src_sel,
    input  logic             osc_tick,
    input  logic             instr_tick,
    input  logic             halted,
    input  logic             clr_wdt,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             timeout_flag,
    output logic             chip_rst_req,
    output logic             warm_rst_req
);
    logic             halt_q;
    logic             halt_entry;
    logic             sw_clear;
    logic             chain_clear;
    logic             sel_tick;
    logic             ovf;
    logic [SEL_W-1:0] ratio_sel;

    wdog_tick_sel u_tick_sel (
        .osc_tick   (osc_tick),
        .instr_tick (instr_tick),
        .src_sel    (src_sel),
        .enable     (wd_enable),
        .halted     (halted),
        .tick_out   (sel_tick)
    );

    wdog_ctrl_reg #(.REG_W(REG_W), .SEL_W(SEL_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .sel   (ratio_sel)
    );

    wdog_counter_chain #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (chain_clear),
        .tick  (sel_tick),
        .sel   (ratio_sel),
        .ovf   (ovf)
    );

    // remember the previous halt state to find halt entry
    always_ff @(posedge clk) begin
        if (!rst_n) halt_q <= 1'b0;
        else        halt_q <= halted;
    end

    // clear sources count only while the watchdog is enabled
    always_comb begin
        halt_entry  = halted && !halt_q;
        sw_clear    = clr_wdt && wd_enable;
        chain_clear = sw_clear || (halt_entry && wd_enable);
    end

    // issue the reset request that matches the halt state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chip_rst_req <= 1'b0;
            warm_rst_req <= 1'b0;
        end else begin
            chip_rst_req <= ovf && !halted;
            warm_rst_req <= ovf && halted;
        end
    end

    // sticky time-out flag, cleared by software clear
    always_ff @(posedge clk) begin
        if (!rst_n)                 timeout_flag <= 1'b0;
        else if (sw_clear)          timeout_flag <= 1'b0;
        else if (ovf && !halted)    timeout_flag <= 1'b1;
    end

    p_one_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chip_rst_req, warm_rst_req}))
        else $error("both reset kinds requested");

    p_chip_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_req |=> !chip_rst_req)
        else $error("chip reset request longer than one cycle");

    p_chip_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_req |-> timeout_flag)
        else $error("chip reset without time-out flag");

    p_warm_in_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst_req |-> $past(halted))
        else $error("warm reset while running");

    p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wd_enable) |-> !(chip_rst_req || warm_rst_req))
        else $error("request while disabled");

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && wdog_src_e'(src_sel) == SRC_INSTR) |-> !ovf)
        else $error("overflow with frozen instruction source");

    p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wdt && wd_enable) |=> !timeout_flag)
        else $error("clear did not drop time-out flag");
endmodule

// File: tb/wdog_top_tb_top.sv
module wdog_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n, wd_enable, src_sel, osc_tick, instr_tick, halted, clr_wdt, reg_we;
    logic [7:0] reg_wdata, reg_rdata;
    logic       timeout_flag, chip_rst_req, warm_rst_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    wdog_top dut_i (
        .clk(clk), .rst_n(rst_n), .wd_enable(wd_enable), .src_sel(src_sel),
        .osc_tick(osc_tick), .instr_tick(instr_tick), .halted(halted),
        .clr_wdt(clr_wdt), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .timeout_flag(timeout_flag),
        .chip_rst_req(chip_rst_req), .warm_rst_req(warm_rst_req)
    );

    // kind: 0 none, 1 chip reset, 2 warm reset
    typedef struct packed {
        logic [2:0] sel;
        logic       src;
        logic       halt;
        logic [1:0] period;
        logic [1:0] kind;
        logic [4:0] flags;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{3'd0, 1'b0, 1'b0, 2'd1, 2'd1, 5'h00},
        '{3'd3, 1'b1, 1'b0, 2'd2, 2'd1, 5'h1F},
        '{3'd7, 1'b0, 1'b0, 2'd1, 2'd1, 5'h15},
        '{3'd2, 1'b0, 1'b1, 2'd1, 2'd2, 5'h0A},
        '{3'd1, 1'b1, 1'b1, 2'd1, 2'd0, 5'h11},
        '{3'd5, 1'b1, 1'b0, 2'd3, 2'd1, 5'h08}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] d);
        reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse_clr();
        clr_wdt = 1'b1;
        @(negedge clk);
        clr_wdt = 1'b0;
    endtask

    // Drive up to maxn selected ticks; the other source is held high throughout.
    // hit_at is the tick index after which a request appeared (0 if none).
    task automatic run_ticks(input logic src, input int maxn, input int period,
                             output int hit_at, output int kind);
        hit_at = 0; kind = 0;
        if (src) osc_tick = 1'b1; else instr_tick = 1'b1;
        for (int i = 1; i <= maxn; i++) begin
            if (src) instr_tick = 1'b1; else osc_tick = 1'b1;
            @(negedge clk);
            if (src) instr_tick = 1'b0; else osc_tick = 1'b0;
            if (chip_rst_req || warm_rst_req) begin
                hit_at = i;
                kind   = chip_rst_req ? 1 : 2;
                break;
            end
            for (int p = 1; p < period; p++) @(negedge clk);
        end
        osc_tick = 1'b0; instr_tick = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int hit, kind, n;
        rst_n = 1'b0; wd_enable = 1'b1; src_sel = 1'b0; osc_tick = 1'b0;
        instr_tick = 1'b0; halted = 1'b0; clr_wdt = 1'b0; reg_we = 1'b0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(reg_rdata == 8'hFF, "R1 reg", reg_rdata, 255);
        chk(timeout_flag == 1'b0, "R1 flag", timeout_flag, 0);
        chk(!chip_rst_req && !warm_rst_req, "R1 req", {chip_rst_req, warm_rst_req}, 0);

        // table walk: R2 ratio, R3 source, R4/R5 request kind, R7 frozen, R9 flags
        foreach (VEC[v]) begin
            n = 256 << VEC[v].sel;
            src_sel = VEC[v].src;
            wr_reg({VEC[v].flags, VEC[v].sel});
            chk(reg_rdata == {VEC[v].flags, VEC[v].sel}, "R9 readback",
                reg_rdata, {VEC[v].flags, VEC[v].sel});
            pulse_clr();
            if (VEC[v].halt) begin halted = 1'b1; @(negedge clk); end
            run_ticks(VEC[v].src, (VEC[v].kind == 0) ? n : n + 4,
                      int'(VEC[v].period), hit, kind);
            if (VEC[v].kind == 0) begin
                chk(hit == 0, "R7 frozen no time-out", hit, 0);
            end else begin
                chk(hit == n, "R2/R3 ticks to time-out", hit, n);
                chk(kind == int'(VEC[v].kind), "R4/R5 request kind", kind, VEC[v].kind);
                chk(timeout_flag == (VEC[v].kind == 1), "R4/R5 flag",
                    timeout_flag, VEC[v].kind == 1);
                @(negedge clk);
                chk(!chip_rst_req && !warm_rst_req, "R4 one-cycle pulse",
                    {chip_rst_req, warm_rst_req}, 0);
            end
            halted = 1'b0;
            @(negedge clk);
        end

        // R10: back-to-back periods at 1:2
        src_sel = 1'b0;
        wr_reg(8'h01);
        pulse_clr();
        run_ticks(1'b0, 600, 1, hit, kind);
        chk(hit == 512, "R10 first period", hit, 512);
        run_ticks(1'b0, 600, 1, hit, kind);
        chk(hit == 512, "R10 second period", hit, 512);

        // R6: clear mid-count restarts and drops the flag
        wr_reg(8'h00);
        chk(timeout_flag == 1'b1, "R6 flag set before clear", timeout_flag, 1);
        run_ticks(1'b0, 200, 1, hit, kind);
        pulse_clr();
        chk(timeout_flag == 1'b0, "R6 flag cleared", timeout_flag, 0);
        run_ticks(1'b0, 300, 1, hit, kind);
        chk(hit == 256, "R6 restart after clear", hit, 256);

        // R6: clear coincident with final tick wins
        pulse_clr();
        run_ticks(1'b0, 255, 1, hit, kind);
        chk(hit == 0, "R6 no early hit", hit, 0);
        osc_tick = 1'b1; clr_wdt = 1'b1;
        @(negedge clk);
        osc_tick = 1'b0; clr_wdt = 1'b0;
        chk(!chip_rst_req && !warm_rst_req, "R6 clear beats overflow",
            {chip_rst_req, warm_rst_req}, 0);
        run_ticks(1'b0, 300, 1, hit, kind);
        chk(hit == 256, "R6 count zeroed by clear", hit, 256);

        // R7: halt entry zeroes the count (oscillator keeps running)
        pulse_clr();
        run_ticks(1'b0, 100, 1, hit, kind);
        halted = 1'b1;
        @(negedge clk);
        run_ticks(1'b0, 300, 1, hit, kind);
        chk(hit == 256, "R7 halt entry clears", hit, 256);
        chk(kind == 2, "R5 warm in halt", kind, 2);
        halted = 1'b0;
        @(negedge clk);

        // R8: disabled ignores ticks, clear and halt entry; resumes held count
        pulse_clr();
        run_ticks(1'b0, 300, 1, hit, kind);
        chk(timeout_flag == 1'b1, "R8 setup flag", timeout_flag, 1);
        run_ticks(1'b0, 100, 1, hit, kind);
        wd_enable = 1'b0;
        run_ticks(1'b0, 500, 1, hit, kind);
        chk(hit == 0, "R8 no request while disabled", hit, 0);
        pulse_clr();
        halted = 1'b1;
        @(negedge clk);
        halted = 1'b0;
        @(negedge clk);
        chk(timeout_flag == 1'b1, "R8 clear ignored", timeout_flag, 1);
        wd_enable = 1'b1;
        run_ticks(1'b0, 300, 1, hit, kind);
        chk(hit == 156, "R8 count held", hit, 156);

        // R11: external reset mid-count
        run_ticks(1'b0, 100, 1, hit, kind);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(reg_rdata == 8'hFF, "R11/R1 reg after reset", reg_rdata, 255);
        chk(timeout_flag == 1'b0, "R11 flag after reset", timeout_flag, 0);
        wr_reg(8'hA0);
        run_ticks(1'b0, 300, 1, hit, kind);
        chk(hit == 256, "R11 restart after reset", hit, 256);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule